// File: doc/BRIEF.md
# Signaling Change Event Queue

This block tracks a per-slot control/indication (C/I) value and a per-slot signaling (SIG) value for every time slot of a multiplexed frame. An upstream sampler writes the newest values for each slot through a sample port. A one-cycle frame strobe marks every 125 µs frame. On each strobe a scan machine walks all slots. It first compares every slot's newest C/I value against the stored one. It then runs a last-look check on the SIG values. Every confirmed change becomes one byte in a 9-entry event queue.

Each queued byte has a valid flag in bit 7 and a 7-bit control-memory address in bits 6..0. The host can copy the byte unchanged into its memory-address register. An even address (2·slot) reports a C/I change. An odd address (2·slot+1) reports a newly stable SIG value. A host-written timer byte sets the last-look period, in frames.

The scan machine has three states. `SC_IDLE` waits for the frame strobe and moves to `SC_CI` when it arrives. `SC_CI` serves one slot per cycle and moves to `SC_SIG` after the last slot. `SC_SIG` serves one slot per cycle and returns to `SC_IDLE` after the last slot. A frame strobe that arrives outside `SC_IDLE` has no effect.

Top module: `sig_event_queue`

## Requirements
- R1: After reset the timer byte is 0x00, the overflow flag is 0 and a read returns 0x00.
- R2: When a slot's newest C/I value differs from its stored value at a frame scan, the byte 0x80 | (2·slot) is queued and the stored value is updated.
- R3: A SIG value is queued as 0x80 | (2·slot+1) only in the scan in which it has been seen unchanged in P consecutive frame scans and differs from the stable value. That scan also makes it the new stable value.
- R4: Timer byte bit 7 = 1 gives P = 1. Bit 7 = 0 gives P = bits 6..0 + 1, so P ranges from 1 to 128 frames.
- R5: Within one frame scan, all C/I events are queued before any SIG event, and each group is queued in ascending slot order, one entry per cycle.
- R6: The queue is first-in first-out and holds up to 9 entries. A read of a non-empty queue returns the oldest entry and removes it.
- R7: A read of an empty queue returns 0x00 (valid flag clear) and leaves the queue unchanged, so the next event queued is the next one read.
- R8: An event that arrives while the queue holds 9 entries is discarded and sets a sticky overflow flag. A pulse on the clear input resets the flag.
- R9: A SIG value that returns to the stable value before P scans have passed queues no event.
- R10: A slot whose C/I and SIG values do not change queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | One-cycle strobe per 125 µs frame; starts a scan |
| smp_we | input | 1 | Writes the newest values of one slot |
| smp_slot | input | $clog2(NUM_SLOTS) | Slot number for the sample write |
| smp_ci | input | CI_W | Newest C/I value |
| smp_sig | input | SIG_W | Newest SIG value |
| tmr_we | input | 1 | Writes the timer byte |
| tmr_wdata | input | 8 | Timer byte: bit 7 rate select, bits 6..0 period value |
| rd_en | input | 1 | Read strobe for the event queue |
| rd_data | output | 8 | Byte returned by the last read |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The in-line assertions check these properties on every cycle:
- the queue level never exceeds nine;
- an empty read yields zero;
- a push into a full queue sets the overflow flag, which then stays set until cleared;
- a rate-select write forces a one-frame period;
- the C/I pass always hands over to the SIG pass at slot zero.

Only the bench scenarios can show the event contents. These are the address parity per event type, the exact frame in which a debounced SIG value is reported, and the silence after a reverting SIG value. They also cover the ordering of a mixed frame and which entries survive an overflow.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int ENTRY_W = 8;
    localparam int ADDR_W  = 7;
    localparam int AGREE_W = 8;
    localparam int TMR_W   = 8;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_CI   = 2'd1,
        SC_SIG  = 2'd2
    } scan_state_e;

    typedef logic [ENTRY_W-1:0] entry_t;

    function automatic entry_t make_entry(input logic [ADDR_W-1:0] addr);
        return {1'b1, addr};
    endfunction
endpackage

// File: rtl/seq_timer.sv
module seq_timer
    import seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tmr_we,
    input  logic [TMR_W-1:0]   tmr_wdata,
    output logic [AGREE_W-1:0] period
);
    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (tmr_we) begin
            tmr_q <= tmr_wdata;
        end
    end

    // fast rate forces a single frame; otherwise value + 1 frames
    always_comb begin
        if (tmr_q[TMR_W-1]) begin
            period = AGREE_W'(1);
        end else begin
            period = AGREE_W'(tmr_q[TMR_W-2:0]) + AGREE_W'(1);
        end
    end

    AST_FAST_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_we && tmr_wdata[TMR_W-1]) |=> (period == AGREE_W'(1))); // R4
endmodule

// File: rtl/seq_fifo.sv
module seq_fifo
    import seq_pkg::*;
#(
    parameter int DEPTH = 9
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  entry_t push_entry,
    input  logic   rd_en,
    input  logic   ovf_clr,
    output entry_t rd_data,
    output logic   ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    entry_t           mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [LVL_W-1:0] level;
    logic             full;
    logic             empty;
    logic             pop;
    logic             accept;

    always_comb begin
        full   = (level == FULL_LVL);
        empty  = (level == '0);
        pop    = rd_en && !empty;
        accept = push && (!full || pop);
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= push_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            rd_data <= '0;
            ovf     <= 1'b0;
        end else begin
            if (accept) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + PTR_W'(1);
            end
            level <= level + LVL_W'(accept) - LVL_W'(pop);
            if (rd_en) begin
                rd_data <= pop ? mem[rd_ptr] : '0;
            end
            if (push && !accept) begin
                ovf <= 1'b1;
            end else if (ovf_clr) begin
                ovf <= 1'b0;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL); // R6
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> (rd_data == '0)); // R7
    AST_DROP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !rd_en) |=> ovf); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf); // R8
endmodule

// File: rtl/seq_scanner.sv
module seq_scanner
    import seq_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int CI_W      = 4,
    parameter int SIG_W     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_tick,
    input  logic                         smp_we,
    input  logic [$clog2(NUM_SLOTS)-1:0] smp_slot,
    input  logic [CI_W-1:0]              smp_ci,
    input  logic [SIG_W-1:0]             smp_sig,
    input  logic [AGREE_W-1:0]           period,
    output logic                         push,
    output entry_t                       push_entry
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [AGREE_W-1:0] AGREE_MAX = '1;

    scan_state_e       state_q;
    scan_state_e       state_nx;
    logic [SLOT_W-1:0] idx_q;
    logic [SLOT_W-1:0] idx_nx;

    logic [CI_W-1:0]    lat_ci_w   [NUM_SLOTS];
    logic [CI_W-1:0]    ci_mem_w   [NUM_SLOTS];
    logic [SIG_W-1:0]   lat_sig_w  [NUM_SLOTS];
    logic [SIG_W-1:0]   cand_w     [NUM_SLOTS];
    logic [SIG_W-1:0]   stab_w     [NUM_SLOTS];
    logic [AGREE_W-1:0] agree_w    [NUM_SLOTS];

    logic               ci_diff;
    logic               sig_same;
    logic [AGREE_W-1:0] agree_nx;
    logic               sig_commit;

    // per-slot value storage
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [CI_W-1:0]    lat_ci_q;
        logic [SIG_W-1:0]   lat_sig_q;
        logic [CI_W-1:0]    ci_mem_q;
        logic [SIG_W-1:0]   cand_q;
        logic [SIG_W-1:0]   stab_q;
        logic [AGREE_W-1:0] agree_q;
        logic               here;

        assign here = (idx_q == SLOT_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lat_ci_q  <= '0;
                lat_sig_q <= '0;
                ci_mem_q  <= '0;
                cand_q    <= '0;
                stab_q    <= '0;
                agree_q   <= '0;
            end else begin
                if (smp_we && (smp_slot == SLOT_W'(s))) begin
                    lat_ci_q  <= smp_ci;
                    lat_sig_q <= smp_sig;
                end
                if (state_q == SC_CI && here && ci_diff) begin
                    ci_mem_q <= lat_ci_q;
                end
                if (state_q == SC_SIG && here) begin
                    cand_q  <= lat_sig_q;
                    agree_q <= agree_nx;
                    if (sig_commit) begin
                        stab_q <= lat_sig_q;
                    end
                end
            end
        end

        assign lat_ci_w[s]  = lat_ci_q;
        assign lat_sig_w[s] = lat_sig_q;
        assign ci_mem_w[s]  = ci_mem_q;
        assign cand_w[s]    = cand_q;
        assign stab_w[s]    = stab_q;
        assign agree_w[s]   = agree_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_nx;
            idx_q   <= idx_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        idx_nx   = idx_q;
        unique case (state_q)
            SC_IDLE: begin
                if (frame_tick) begin
                    state_nx = SC_CI;
                    idx_nx   = '0;
                end
            end
            SC_CI: begin
                if (idx_q == LAST_SLOT) begin
                    state_nx = SC_SIG;
                    idx_nx   = '0;
                end else begin
                    idx_nx = idx_q + SLOT_W'(1);
                end
            end
            SC_SIG: begin
                if (idx_q == LAST_SLOT) begin
                    state_nx = SC_IDLE;
                    idx_nx   = '0;
                end else begin
                    idx_nx = idx_q + SLOT_W'(1);
                end
            end
            default: begin
                state_nx = SC_IDLE;
                idx_nx   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        ci_diff  = (lat_ci_w[idx_q] != ci_mem_w[idx_q]);
        sig_same = (lat_sig_w[idx_q] == cand_w[idx_q]);
        if (!sig_same) begin
            agree_nx = AGREE_W'(1);
        end else if (agree_w[idx_q] == AGREE_MAX) begin
            agree_nx = AGREE_MAX;
        end else begin
            agree_nx = agree_w[idx_q] + AGREE_W'(1);
        end
        sig_commit = (agree_nx >= period) && (lat_sig_w[idx_q] != stab_w[idx_q]);
        push       = 1'b0;
        push_entry = '0;
        unique case (state_q)
            SC_IDLE: begin
                push = 1'b0;
            end
            SC_CI: begin
                push       = ci_diff;
                push_entry = make_entry(ADDR_W'({idx_q, 1'b0}));
            end
            SC_SIG: begin
                push       = sig_commit;
                push_entry = make_entry(ADDR_W'({idx_q, 1'b1}));
            end
            default: begin
                push = 1'b0;
            end
        endcase
    end

    AST_CI_THEN_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_CI && idx_q == LAST_SLOT) |=> (state_q == SC_SIG && idx_q == '0)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_IDLE) |-> !push); // R10
endmodule

// File: rtl/sig_event_queue.sv
module sig_event_queue
    import seq_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int CI_W       = 4,
    parameter int SIG_W      = 4,
    parameter int FIFO_DEPTH = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_tick,
    input  logic                         smp_we,
    input  logic [$clog2(NUM_SLOTS)-1:0] smp_slot,
    input  logic [CI_W-1:0]              smp_ci,
    input  logic [SIG_W-1:0]             smp_sig,
    input  logic                         tmr_we,
    input  logic [7:0]                   tmr_wdata,
    input  logic                         rd_en,
    output logic [7:0]                   rd_data,
    input  logic                         ovf_clr,
    output logic                         ovf_flag
);
    logic [AGREE_W-1:0] period;
    logic               push;
    entry_t             push_entry;
    entry_t             rd_entry;

    seq_timer u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmr_we    (tmr_we),
        .tmr_wdata (tmr_wdata),
        .period    (period)
    );

    seq_scanner #(
        .NUM_SLOTS (NUM_SLOTS),
        .CI_W      (CI_W),
        .SIG_W     (SIG_W)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .smp_we     (smp_we),
        .smp_slot   (smp_slot),
        .smp_ci     (smp_ci),
        .smp_sig    (smp_sig),
        .period     (period),
        .push       (push),
        .push_entry (push_entry)
    );

    seq_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (push_entry),
        .rd_en      (rd_en),
        .ovf_clr    (ovf_clr),
        .rd_data    (rd_entry),
        .ovf        (ovf_flag)
    );

    assign rd_data = rd_entry;

    AST_READ_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] || rd_data == 8'h00)); // R7
endmodule

// File: tb/sig_event_queue_test.sv
`timescale 1ns/1ps
module sig_event_queue_test;
    localparam int N  = 8;
    localparam int CW = 4;
    localparam int SW = 4;
    localparam int D  = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_tick = 1'b0;
    logic         smp_we = 1'b0;
    logic [2:0]   smp_slot = '0;
    logic [CW-1:0] smp_ci = '0;
    logic [SW-1:0] smp_sig = '0;
    logic         tmr_we = 1'b0;
    logic [7:0]   tmr_wdata = '0;
    logic         rd_en = 1'b0;
    logic [7:0]   rd_data;
    logic         ovf_clr = 1'b0;
    logic         ovf_flag;

    always #2.5 clk = ~clk;

    sig_event_queue uut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .smp_we(smp_we), .smp_slot(smp_slot), .smp_ci(smp_ci), .smp_sig(smp_sig),
        .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .rd_en(rd_en), .rd_data(rd_data),
        .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int lat_ci [N];
    int lat_sig[N];
    int m_ci   [N];
    int m_cand [N];
    int m_stab [N];
    int m_agree[N];
    logic [7:0] mq[$];
    bit m_ovf = 0;
    logic [7:0] m_tmr = 8'h00;

    function automatic int period_f();
        return m_tmr[7] ? 1 : int'(m_tmr[6:0]) + 1;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic void mpush(logic [7:0] e);
        if (mq.size() < D) mq.push_back(e);
        else m_ovf = 1;
    endfunction

    task automatic set_slot(int s, int ci, int sg);
        smp_slot = 3'(s); smp_ci = CW'(ci); smp_sig = SW'(sg); smp_we = 1'b1;
        @(negedge clk);
        smp_we = 1'b0;
        lat_ci[s]  = ci % 16;
        lat_sig[s] = sg % 16;
    endtask

    task automatic wr_tmr(logic [7:0] v);
        tmr_wdata = v; tmr_we = 1'b1;
        @(negedge clk);
        tmr_we = 1'b0;
        m_tmr = v;
    endtask

    task automatic frame();
        int p;
        for (int s = 0; s < N; s++) begin
            if (lat_ci[s] != m_ci[s]) begin
                m_ci[s] = lat_ci[s];
                mpush(8'h80 | 8'(2 * s));
            end
        end
        p = period_f();
        for (int s = 0; s < N; s++) begin
            if (lat_sig[s] == m_cand[s]) m_agree[s] = (m_agree[s] >= 255) ? 255 : m_agree[s] + 1;
            else m_agree[s] = 1;
            m_cand[s] = lat_sig[s];
            if (m_agree[s] >= p && lat_sig[s] != m_stab[s]) begin
                m_stab[s] = lat_sig[s];
                mpush(8'h80 | 8'(2 * s + 1));
            end
        end
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        repeat (2 * N + 3) @(negedge clk);
    endtask

    task automatic do_read(output logic [7:0] v);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic read_chk(string req);
        logic [7:0] v;
        logic [7:0] e;
        do_read(v);
        e = (mq.size() > 0) ? mq.pop_front() : 8'h00;
        check(req, v, e);
    endtask

    task automatic read_exp(string req, logic [7:0] exp);
        logic [7:0] v;
        do_read(v);
        if (mq.size() > 0) void'(mq.pop_front());
        check(req, v, exp);
    endtask

    task automatic clr_ovf();
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        m_ovf = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        for (int s = 0; s < N; s++) begin
            lat_ci[s] = 0; lat_sig[s] = 0; m_ci[s] = 0;
            m_cand[s] = 0; m_stab[s] = 0; m_agree[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 ovf", 8'(ovf_flag), 8'h00);
        read_exp("R1", 8'h00);

        // R2 then R7: empty read keeps pointer
        set_slot(3, 5, 0);
        frame();
        read_exp("R2", 8'h86);
        read_exp("R7 empty", 8'h00);
        set_slot(2, 1, 0);
        frame();
        read_exp("R7 after empty", 8'h84);

        // R3 / R4: period 4 frames
        wr_tmr(8'h03);
        set_slot(2, 1, 9);
        for (int f = 0; f < 3; f++) begin
            frame();
            read_exp("R3 early", 8'h00);
        end
        frame();
        read_exp("R3 stable", 8'h85);

        // R4: fast rate
        wr_tmr(8'h83);
        set_slot(5, 0, 3);
        frame();
        read_exp("R4 fast", 8'h8B);

        // R9: bounce that reverts
        wr_tmr(8'h02);
        set_slot(1, 0, 6);
        frame();
        frame();
        set_slot(1, 0, 0);
        frame(); frame(); frame();
        read_exp("R9", 8'h00);

        // R10: nothing changed
        frame();
        read_exp("R10", 8'h00);

        // R5: mixed ordering
        wr_tmr(8'h80);
        set_slot(6, 2, 0);
        set_slot(1, 7, 0);
        set_slot(4, 0, 1);
        set_slot(0, 0, 2);
        frame();
        read_exp("R5 ci1", 8'h82);
        read_exp("R5 ci6", 8'h8C);
        read_exp("R5 sig0", 8'h81);
        read_exp("R5 sig4", 8'h89);

        // R6 / R8: overflow with 16 events
        for (int s = 0; s < N; s++) set_slot(s, (lat_ci[s] + 1) % 16, (lat_sig[s] + 1) % 16);
        frame();
        check("R8 set", 8'(ovf_flag), 8'h01);
        for (int k = 0; k < N; k++) read_exp("R6 fifo", 8'h80 | 8'(2 * k));
        read_exp("R6 ninth", 8'h81);
        read_exp("R6 drained", 8'h00);
        check("R8 sticky", 8'(ovf_flag), 8'h01);
        clr_ovf();
        check("R8 clear", 8'(ovf_flag), 8'h00);

        // random mix checked against the model
        for (int f = 0; f < 300; f++) begin
            if ($urandom_range(0, 9) == 0) begin
                if ($urandom_range(0, 2) == 0) wr_tmr(8'h80 | 8'($urandom_range(0, 127)));
                else wr_tmr(8'($urandom_range(0, 3)));
            end
            for (int s = 0; s < N; s++) begin
                int r;
                r = int'($urandom_range(0, 7));
                if (r == 0) set_slot(s, int'($urandom_range(0, 15)), lat_sig[s]);
                else if (r == 1) set_slot(s, lat_ci[s], int'($urandom_range(0, 1)));
            end
            frame();
            check("R8 rand", 8'(ovf_flag), 8'(m_ovf));
            for (int k = int'($urandom_range(0, 4)); k > 0; k--) read_chk("R6 rand");
            if ($urandom_range(0, 5) == 0) clr_ovf();
        end
        while (mq.size() > 0) read_chk("R6 drain");
        read_chk("R7 final");

        done = 1;
        summary();
        $finish;
    end
endmodule